// File: doc/BRIEF.md
# Radio Receive Packet Reader with Additive Checksum

This block drives the serial control port of a radio receiver once the receiver has been set up. It arms the receiver's byte queue with a fixed 16-bit command and then handles each byte in turn. For each byte it waits for the active-low interrupt line to go low, then runs a 24-clock read cycle and keeps the last 8 bits. A packet is 16 payload bytes, then a checksum byte, then one trailing byte that is discarded. After the trailing byte the block disarms the queue with a second command.

The payload is held in a small buffer and sent out on a valid/ready byte stream. After the last payload byte is accepted, a one-cycle completion pulse carries the verdict. The packet is good when the 8-bit wrapping sum of the payload equals the checksum byte. A status bit toggles on every good packet. The block then re-arms the queue and waits for the next packet for as long as `run` stays high.

Top module: `pkt_rx_top`

## Requirements
- R1: While `rst` is high, and while `run` stays low after reset, `sel_n` is 1, `sclk` is 0, and `out_valid`, `pkt_done` and `status` are all 0. No transfer takes place.
- R2: After `run` rises, the first transfer is a 16-clock command with the value 0xCE8B (arm). It is sent MSB first on `mosi`, and each bit is valid at the rising edge of `sclk`.
- R3: A byte read starts only after `irq_n` has been seen low. While `irq_n` stays high, no read starts, however long that lasts.
- R4: A byte read keeps `sel_n` low for exactly 24 rising edges of `sclk`, with `mosi` held at 0 for the whole read.
- R5: `miso` is sampled before each rising edge of `sclk` and shifted in MSB first. The data byte is the last 8 bits sampled, so the first 16 bits of a read have no effect on it.
- R6: Exactly 18 reads are made per packet. Then comes a 16-clock disarm command of value 0xCE00, and only after that does streaming start. Once a packet has been reported, the arm command 0xCE8B is sent again.
- R7: The 16 payload bytes appear on `out_data` in the order they were received. Each byte is transferred when `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and `out_data` hold.
- R8: One cycle after the last payload byte is accepted, `pkt_done` pulses for exactly one cycle. At the same time `pkt_good` is 1 if and only if (sum of the 16 payload bytes) mod 256 equals the checksum byte, which is the 17th byte read.
- R9: `status` changes on every good packet and stays unchanged on every bad one. The change appears in the same cycle as `pkt_done`.
- R10: `sclk` is low whenever `sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows the block to take over the port and receive packets |
| irq_n | input | 1 | Active-low byte-ready line from the receiver (asynchronous) |
| miso | input | 1 | Serial data from the receiver |
| sel_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the receiver |
| out_data | output | 8 | Payload byte |
| out_valid | output | 1 | `out_data` holds a payload byte |
| out_ready | input | 1 | Downstream accepts the byte |
| pkt_done | output | 1 | One-cycle pulse at packet completion |
| pkt_good | output | 1 | Checksum verdict, valid with `pkt_done` |
| status | output | 1 | Toggles on each good packet |

## Verification
The assertions assume two things about the receiver. First, it raises `irq_n` as soon as a read selects it. Second, it lowers `irq_n` again only while the port is idle. Together these mean a stale low level can never start a second read. The bench's receiver model keeps to this: it raises the line on every select, and lowers it only after a gap of idle cycles and while bytes remain in the armed packet. The assertions also assume `out_ready` may toggle freely. The stimulus exercises this with a repeating backpressure pattern.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [1:0] {
    SX_IDLE,
    SX_LOW,
    SX_HIGH,
    SX_END
  } sx_state_e;

  typedef enum logic [3:0] {
    PK_IDLE,
    PK_ARM,
    PK_ARM_WAIT,
    PK_IRQ,
    PK_READ_WAIT,
    PK_DISARM,
    PK_DIS_WAIT,
    PK_FETCH,
    PK_LOAD,
    PK_SHOW,
    PK_DONE
  } pk_state_e;

endpackage

// File: rtl/pkt_rx_serial.sv
module pkt_rx_serial
  import pkt_rx_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int CMD_BITS  = 16,
  parameter int READ_BITS = 24,
  parameter int BYTE_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                rd_mode,
  input  logic [CMD_BITS-1:0] tx_word,
  input  logic                miso,
  output logic                sel_n,
  output logic                sclk,
  output logic                mosi,
  output logic                done,
  output logic [BYTE_W-1:0]   rx_byte
);

  localparam int TMR_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BC_W  = $clog2(READ_BITS + 1);

  sx_state_e           st;
  logic [TMR_W-1:0]    tmr;
  logic [BC_W-1:0]     bcnt;
  logic [BC_W-1:0]     last;
  logic [CMD_BITS-1:0] shreg;
  logic                is_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SX_IDLE;
      sel_n   <= 1'b1;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      tmr     <= '0;
      bcnt    <= '0;
      last    <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SX_IDLE: begin
          if (start) begin
            sel_n <= 1'b0;
            sclk  <= 1'b0;
            tmr   <= '0;
            bcnt  <= '0;
            is_rd <= rd_mode;
            shreg <= rd_mode ? '0 : tx_word;
            mosi  <= rd_mode ? 1'b0 : tx_word[CMD_BITS-1];
            last  <= rd_mode ? BC_W'(READ_BITS - 1) : BC_W'(CMD_BITS - 1);
            st    <= SX_LOW;
          end
        end
        SX_LOW: begin
          if (tmr == TMR_W'(HALF_CYC - 1)) begin
            tmr     <= '0;
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[BYTE_W-2:0], miso};
            st      <= SX_HIGH;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        SX_HIGH: begin
          if (tmr == TMR_W'(HALF_CYC - 1)) begin
            tmr  <= '0;
            sclk <= 1'b0;
            if (bcnt == last) begin
              st <= SX_END;
            end else begin
              bcnt  <= bcnt + 1'b1;
              shreg <= shreg << 1;
              mosi  <= shreg[CMD_BITS-2];
              st    <= SX_LOW;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          sel_n <= 1'b1;
          mosi  <= 1'b0;
          done  <= 1'b1;
          st    <= SX_IDLE;
        end
      endcase
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (rst)
    sel_n |-> !sclk); // R10

  AST_READ_MOSI_LOW: assert property (@(posedge clk) disable iff (rst)
    (is_rd && !sel_n) |-> !mosi); // R4

  AST_BITS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    bcnt <= last); // R4

endmodule

// File: rtl/pkt_rx_buf.sv
module pkt_rx_buf #(
  parameter int DEPTH  = 16,
  parameter int WIDTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pkt_rx_top.sv
module pkt_rx_top
  import pkt_rx_pkg::*;
#(
  parameter int          PAYLOAD_BYTES = 16,
  parameter int          TRAIL_BYTES   = 1,
  parameter int          HALF_CYC      = 2,
  parameter int          SYNC_STAGES   = 2,
  parameter logic [15:0] ARM_CMD       = 16'hCE8B,
  parameter logic [15:0] DISARM_CMD    = 16'hCE00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       irq_n,
  input  logic       miso,
  output logic       sel_n,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       pkt_done,
  output logic       pkt_good,
  output logic       status
);

  localparam int TOTAL_BYTES = PAYLOAD_BYTES + 1 + TRAIL_BYTES;
  localparam int IDX_W       = $clog2(TOTAL_BYTES);
  localparam int ADDR_W      = $clog2(PAYLOAD_BYTES);

  pk_state_e            st;
  logic [SYNC_STAGES-1:0] irq_sync;
  logic                 irq_low;
  logic [IDX_W-1:0]     idx;
  logic [ADDR_W-1:0]    sidx;
  logic [7:0]           sum;
  logic [7:0]           chk_byte;
  logic                 xs_start;
  logic                 xs_rd;
  logic [15:0]          xs_word;
  logic                 xs_done;
  logic [7:0]           xs_byte;
  logic                 buf_we;
  logic [7:0]           buf_rd;

  always_ff @(posedge clk) begin
    if (rst) irq_sync <= '1;
    else     irq_sync <= {irq_sync[SYNC_STAGES-2:0], irq_n};
  end
  assign irq_low = !irq_sync[SYNC_STAGES-1];

  pkt_rx_serial #(
    .HALF_CYC (HALF_CYC),
    .CMD_BITS (16),
    .READ_BITS(24),
    .BYTE_W   (8)
  ) xfer_i (
    .clk    (clk),
    .rst    (rst),
    .start  (xs_start),
    .rd_mode(xs_rd),
    .tx_word(xs_word),
    .miso   (miso),
    .sel_n  (sel_n),
    .sclk   (sclk),
    .mosi   (mosi),
    .done   (xs_done),
    .rx_byte(xs_byte)
  );

  always_comb begin
    buf_we = (st == PK_READ_WAIT) && xs_done && (idx < IDX_W'(PAYLOAD_BYTES));
  end

  pkt_rx_buf #(
    .DEPTH(PAYLOAD_BYTES),
    .WIDTH(8)
  ) buf_i (
    .clk    (clk),
    .wr_en  (buf_we),
    .wr_addr(idx[ADDR_W-1:0]),
    .wr_data(xs_byte),
    .rd_addr(sidx),
    .rd_data(buf_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= PK_IDLE;
      idx       <= '0;
      sidx      <= '0;
      sum       <= '0;
      chk_byte  <= '0;
      xs_start  <= 1'b0;
      xs_rd     <= 1'b0;
      xs_word   <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      pkt_done  <= 1'b0;
      pkt_good  <= 1'b0;
      status    <= 1'b0;
    end else begin
      xs_start <= 1'b0;
      pkt_done <= 1'b0;
      case (st)
        PK_IDLE: begin
          idx <= '0;
          sum <= '0;
          if (run) st <= PK_ARM;
        end
        PK_ARM: begin
          xs_start <= 1'b1;
          xs_rd    <= 1'b0;
          xs_word  <= ARM_CMD;
          st       <= PK_ARM_WAIT;
        end
        PK_ARM_WAIT: if (xs_done) st <= PK_IRQ;
        PK_IRQ: begin
          if (irq_low) begin
            xs_start <= 1'b1;
            xs_rd    <= 1'b1;
            st       <= PK_READ_WAIT;
          end
        end
        PK_READ_WAIT: begin
          if (xs_done) begin
            if (idx < IDX_W'(PAYLOAD_BYTES)) sum <= sum + xs_byte;
            else if (idx == IDX_W'(PAYLOAD_BYTES)) chk_byte <= xs_byte;
            if (idx == IDX_W'(TOTAL_BYTES - 1)) begin
              st <= PK_DISARM;
            end else begin
              idx <= idx + 1'b1;
              st  <= PK_IRQ;
            end
          end
        end
        PK_DISARM: begin
          xs_start <= 1'b1;
          xs_rd    <= 1'b0;
          xs_word  <= DISARM_CMD;
          st       <= PK_DIS_WAIT;
        end
        PK_DIS_WAIT: begin
          if (xs_done) begin
            sidx <= '0;
            st   <= PK_FETCH;
          end
        end
        PK_FETCH: st <= PK_LOAD;
        PK_LOAD: begin
          out_data  <= buf_rd;
          out_valid <= 1'b1;
          st        <= PK_SHOW;
        end
        PK_SHOW: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            if (sidx == ADDR_W'(PAYLOAD_BYTES - 1)) begin
              st <= PK_DONE;
            end else begin
              sidx <= sidx + 1'b1;
              st   <= PK_FETCH;
            end
          end
        end
        default: begin
          pkt_done <= 1'b1;
          pkt_good <= (sum == chk_byte);
          if (sum == chk_byte) status <= ~status;
          idx <= '0;
          sum <= '0;
          st  <= run ? PK_ARM : PK_IDLE;
        end
      endcase
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done); // R8

  AST_STATUS_ONLY_GOOD: assert property (@(posedge clk) disable iff (rst)
    !$stable(status) |-> (pkt_done && pkt_good)); // R9

  AST_GOOD_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    (pkt_done && pkt_good) |-> (status != $past(status))); // R9

  AST_STREAM_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sel_n); // R6

endmodule

// File: tb/pkt_rx_top_tb_top.sv
module pkt_rx_top_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       irq_n = 1'b1;
  logic       miso = 1'b0;
  logic       out_ready = 1'b0;
  logic       sel_n, sclk, mosi;
  logic [7:0] out_data;
  logic       out_valid, pkt_done, pkt_good, status;

  pkt_rx_top dut_i (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .irq_n    (irq_n),
    .miso     (miso),
    .sel_n    (sel_n),
    .sclk     (sclk),
    .mosi     (mosi),
    .out_data (out_data),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .pkt_done (pkt_done),
    .pkt_good (pkt_good),
    .status   (status)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Receiver model state
  logic [7:0]  byte_q[$];
  logic [7:0]  exp_pay[$];
  bit          exp_good[$];
  bit          armed = 0;
  int          remain = 0;
  int          gap = 0;
  logic        sel_q = 1'b1, sclk_q = 1'b0;
  int          bitc = 0;
  logic [23:0] cap = '0;
  logic [23:0] word = '0;
  bit          irq_at_start = 0;
  int          rd_total = 0;
  int          cmd_n = 0;
  int          reads_in_pkt = 0;
  int          streamed = 0;
  int          pkts = 0;
  int          sel_falls = 0;
  int          cyc = 0;
  logic        exp_status = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      // R10: idle clock level
      if (sel_n && sclk) chk(1'b0, "R10", 32'(sclk), 32'h0);
      if (!sel_n && sel_q) begin
        sel_falls++;
        bitc = 0;
        cap  = '0;
        irq_at_start = !irq_n;
        word = {16'hB5A3 ^ 16'(rd_total), (byte_q.size() > 0) ? byte_q[0] : 8'h00};
        miso = word[23];
        irq_n = 1'b1;
      end
      if (!sel_n && sclk && !sclk_q) begin
        cap = {cap[22:0], mosi};
        bitc++;
        if (bitc < 24) miso = word[23-bitc];
      end
      if (sel_n && !sel_q) begin
        if (bitc == 16) begin
          if (cmd_n % 2 == 0) begin
            chk(cap[15:0] == 16'hCE8B, "R2", 32'(cap[15:0]), 32'hCE8B);
            armed = 1;
            remain = 18;
            reads_in_pkt = 0;
            gap = (cmd_n == 2) ? 400 : 4;
          end else begin
            chk(cap[15:0] == 16'hCE00, "R6", 32'(cap[15:0]), 32'hCE00);
            chk(reads_in_pkt == 18, "R6", 32'(reads_in_pkt), 32'd18);
            armed = 0;
          end
          cmd_n++;
        end else if (bitc == 24) begin
          chk(irq_at_start, "R3", 32'(irq_at_start), 32'h1);
          chk(cap == 24'h0, "R4", 32'(cap), 32'h0);
          chk(armed && remain > 0, "R6", 32'(remain), 32'h1);
          if (byte_q.size() > 0) void'(byte_q.pop_front());
          remain--;
          reads_in_pkt++;
          rd_total++;
          gap = 4;
        end else begin
          chk(1'b0, "R4", 32'(bitc), 32'd24);
        end
      end
      if (gap > 0) gap--;
      else if (armed && remain > 0 && byte_q.size() > 0 && sel_n && irq_n) irq_n = 1'b0;
      sel_q  = sel_n;
      sclk_q = sclk;

      // Downstream: set ready for the coming edge, then predict the transfer
      out_ready = (cyc % 3) != 1;
      cyc++;
      if (out_valid && out_ready) begin
        logic [7:0] e;
        e = (exp_pay.size() > 0) ? exp_pay.pop_front() : 8'hXX;
        chk(out_data === e, "R5 R7", 32'(out_data), 32'(e));
        chk(!armed, "R6", 32'(armed), 32'h0);
        streamed++;
      end
      if (pkt_done) begin
        bit g;
        g = (exp_good.size() > 0) ? exp_good.pop_front() : 1'b0;
        chk(pkt_good == g, "R8", 32'(pkt_good), 32'(g));
        chk(streamed == 16, "R8", 32'(streamed), 32'd16);
        if (g) exp_status = ~exp_status;
        chk(status == exp_status, "R9", 32'(status), 32'(exp_status));
        streamed = 0;
        pkts++;
      end
    end
  end

  initial begin
    int guard;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] s;
      s = 8'h00;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] b;
        case (p)
          0: b = 8'h10 + 8'(i);
          1: b = 8'h30 + 8'(i);
          2: b = 8'hFF;
          default: b = 8'(i * 17);
        endcase
        byte_q.push_back(b);
        exp_pay.push_back(b);
        s = s + b;
      end
      byte_q.push_back((p == 1) ? s + 8'h01 : s);
      byte_q.push_back(8'h5A ^ 8'(p));
      exp_good.push_back(p != 1);
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sel_n == 1'b1, "R1", 32'(sel_n), 32'h1);
    chk(sclk == 1'b0, "R1", 32'(sclk), 32'h0);
    chk(out_valid == 1'b0, "R1", 32'(out_valid), 32'h0);
    chk(status == 1'b0, "R1", 32'(status), 32'h0);
    chk(pkt_done == 1'b0, "R1", 32'(pkt_done), 32'h0);
    rst = 1'b0;
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk(sel_falls == 0, "R1", 32'(sel_falls), 32'h0);
    run = 1'b1;

    guard = 0;
    while (pkts < 4 && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (guard >= 150000) chk(1'b0, "R8 watchdog", 32'(pkts), 32'd4);

    repeat (2000) @(posedge clk);
    @(negedge clk);
    chk(rd_total == 72, "R3", 32'(rd_total), 32'd72);
    chk(cmd_n == 9, "R6", 32'(cmd_n), 32'd9);
    chk(armed == 1, "R6", 32'(armed), 32'h1);
    chk(sel_n == 1'b1, "R3", 32'(sel_n), 32'h1);
    chk(exp_pay.size() == 0, "R7", 32'(exp_pay.size()), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule